// File: doc/BRIEF.md
# Fuse Array Word Read Controller

This block puts a one-time-programmable fuse array behind a small register bus and reads it back one word at a time. Software latches a word index with a separate pulse bit, launches a read with a start bit, polls a busy flag and then collects the result from a data register. The array holds 512 bytes. At reset it is filled with a pattern set by parameters, and a byte-wide test load port can overwrite single bytes afterwards.

One engine serves two word sizes, picked by the `WORD_BYTES` parameter. With one byte per word, each read returns one byte. With four bytes per word, each read returns four consecutive bytes. In both cases the byte offset is the latched index times the word size. An optional key XOR can be applied to the returned word. The controls for fuse programming are kept as plain storage only and have no effect on the array.

Top module: `efuse_rd_ctrl`

## Requirements
- R1: After reset the control register (offset 0x04) reads 0x0800_0000, with power-down (bit 27) set and every other bit clear. The data register (0x08) and the key register (0x10) read 0.
- R2: The word index used by a read is taken from control bits 10:0 only on a write that changes the address-set bit (bit 11) from 0 to 1. A write to the index field without such a rising edge leaves the index of later reads unchanged.
- R3: A control write that changes read-start (bit 25) from 0 to 1, with read-enable (bit 24) at 1 and power-down (bit 27) at 0 in the same write, sets read-busy (bit 26). Busy already reads 1 on the first register read after that write, and it stays 1 for exactly `RD_LAT` clock cycles.
- R4: A start write is ignored in three cases: read-enable is 0, power-down is 1, or busy is already set. An ignored start does not change busy or the time at which busy clears.
- R5: With four bytes per word, the result for index k holds fuse bytes 4k to 4k+3. Byte 4k is in bits 7:0 and byte 4k+3 is in bits 31:24.
- R6: With one byte per word, the result for index k is fuse byte k in bits 7:0, and bits 31:8 are 0.
- R7: While bit 10 of the key register (0x10) is 1, the data register reads the stored word XOR the `KEY` parameter. While that bit is 0 it reads the raw word.
- R8: An index whose word would extend past byte 511 returns a raw word of 0. This is index 128 and above with four bytes per word, and index 512 and above with one byte per word.
- R9: Control bits 23:16, 13 and 12 read back the last value written to them. Bit 14 always reads 0. Writes to the data register have no effect.
- R10: A test load write stores `ld_data` at byte `ld_addr`, and later reads return the new byte.
- R11: Reset fills fuse byte i with (i*`INIT_MUL` + `INIT_ADD`) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; reg_rdata is 0 when this is low |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| ld_we | input | 1 | Test load write strobe |
| ld_addr | input | 9 | Test load byte address |
| ld_data | input | 8 | Test load byte |

## Verification
The bench reads busy on the bus access right after the start write. A design that raised busy one cycle late would show 0 there. It counts the polling cycles to catch an off-by-one in the latency. It re-issues a start while busy, because a design that restarted its counter would clear busy two cycles late. It changes the index field without the address-set edge, because a design that tracked the field directly would return the wrong word. It reads index 127 and index 128 to catch a bound that is off by one word, and it reads the upper bits in the one-byte mode to catch stale or unmasked high bytes.

// File: rtl/efuse_rd_ctrl.sv
module efuse_rd_ctrl #(
  parameter int          WORD_BYTES = 4,
  parameter int          RD_LAT     = 8,
  parameter int          FUSE_BYTES = 512,
  parameter logic [7:0]  INIT_MUL   = 8'd3,
  parameter logic [7:0]  INIT_ADD   = 8'h5A,
  parameter logic [31:0] KEY        = 32'hA5A5_0F0F
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [4:0]                    reg_addr,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic                          ld_we,
  input  logic [$clog2(FUSE_BYTES)-1:0] ld_addr,
  input  logic [7:0]                    ld_data
);
  localparam logic [4:0] CTRL_OFF = 5'h04;
  localparam logic [4:0] DATA_OFF = 5'h08;
  localparam logic [4:0] KEYC_OFF = 5'h10;
  localparam int FA = $clog2(FUSE_BYTES);
  localparam int CW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;

  logic [7:0]  fuse [FUSE_BYTES];
  logic        pd_q, busy_q, start_q, ren_q, wstart_q, wen_q, aset_q, enc_q;
  logic [7:0]  wdat_q;
  logic [10:0] afield_q, lat_q, rd_idx_q;
  logic [CW-1:0] cnt_q;
  logic [31:0] data_q, fetch;

  wire ctrl_wr   = reg_wr && (reg_addr == CTRL_OFF);
  wire aset_rise = ctrl_wr && reg_wdata[11] && !aset_q;
  wire go        = ctrl_wr && reg_wdata[25] && !start_q && reg_wdata[24]
                   && !reg_wdata[27] && !busy_q;
  wire done      = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FUSE_BYTES; i++)
        fuse[i] <= 8'(i * int'(INIT_MUL) + int'(INIT_ADD));
    end else if (ld_we) begin
      fuse[ld_addr] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_q     <= 1'b1;
      start_q  <= 1'b0;
      ren_q    <= 1'b0;
      wdat_q   <= '0;
      wstart_q <= 1'b0;
      wen_q    <= 1'b0;
      aset_q   <= 1'b0;
      afield_q <= '0;
      lat_q    <= '0;
      enc_q    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        pd_q     <= reg_wdata[27];
        start_q  <= reg_wdata[25];
        ren_q    <= reg_wdata[24];
        wdat_q   <= reg_wdata[23:16];
        wstart_q <= reg_wdata[13];
        wen_q    <= reg_wdata[12];
        aset_q   <= reg_wdata[11];
        afield_q <= reg_wdata[10:0];
      end
      if (aset_rise) lat_q <= reg_wdata[10:0];
      if (reg_wr && reg_addr == KEYC_OFF) enc_q <= reg_wdata[10];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      rd_idx_q <= '0;
      data_q   <= '0;
    end else if (go) begin
      busy_q   <= 1'b1;
      cnt_q    <= CW'(RD_LAT - 1);
      rd_idx_q <= lat_q;
    end else if (done) begin
      busy_q <= 1'b0;
      data_q <= fetch;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    fetch = '0;
    if (int'(rd_idx_q) * WORD_BYTES + WORD_BYTES <= FUSE_BYTES)
      for (int b = 0; b < WORD_BYTES; b++)
        fetch[8*b +: 8] = fuse[FA'(int'(rd_idx_q) * WORD_BYTES + b)];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd)
      case (reg_addr)
        CTRL_OFF: reg_rdata = {4'b0, pd_q, busy_q, start_q, ren_q, wdat_q,
                               2'b0, wstart_q, wen_q, aset_q, afield_q};
        DATA_OFF: reg_rdata = data_q ^ (enc_q ? KEY : 32'h0);
        KEYC_OFF: reg_rdata = {21'b0, enc_q, 10'b0};
        default:  reg_rdata = '0;
      endcase
  end
endmodule

module efuse_rd_ctrl_chk #(
  parameter int WORD_BYTES = 4,
  parameter int RD_LAT     = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  reg_addr,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        busy,
  input logic        aset,
  input logic        enc,
  input logic [10:0] lat
);
  logic [31:0] bcnt;
  always_ff @(posedge clk)
    if (!rst_n || !busy) bcnt <= '0;
    else bcnt <= bcnt + 1;

  AST_BUSY_RISE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == 5'h04 && reg_wdata[25])); // R3
  AST_START_NEEDS_EN_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wdata[24] && !reg_wdata[27])); // R4
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == 32'(RD_LAT))); // R3
  AST_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 5'h04 && reg_wdata[11] && !aset) |=> $stable(lat)); // R2
  AST_WBUSY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 5'h04) |-> !reg_rdata[14]); // R9
  AST_BYTE_MODE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (WORD_BYTES == 1 && reg_rd && reg_addr == 5'h08 && !enc) |-> (reg_rdata[31:8] == 24'h0)); // R6
endmodule

bind efuse_rd_ctrl efuse_rd_ctrl_chk #(.WORD_BYTES(WORD_BYTES), .RD_LAT(RD_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy_q), .aset(aset_q),
  .enc(enc_q), .lat(lat_q));

// File: tb/tb_efuse_rd_ctrl.sv
module tb_efuse_rd_ctrl;
  localparam int TCLK = 10;
  localparam int LAT  = 8;
  localparam logic [4:0] CTRL = 5'h04, DATA = 5'h08, KEYC = 5'h10;
  localparam int NV = 7;
  localparam logic [43:0] VEC [NV] = '{
    {11'd0,    1'b0, 32'h63605D5A},
    {11'd1,    1'b0, 32'h6F6C6966},
    {11'd10,   1'b0, 32'hDBD8D5D2},
    {11'd127,  1'b0, 32'h5754514E},
    {11'd1,    1'b1, 32'hCAC96669},
    {11'd128,  1'b0, 32'h00000000},
    {11'd2047, 1'b1, 32'hA5A50F0F}
  };

  logic clk = 0, rst_n = 0;
  logic [4:0] r_addr = 0, s_addr = 0;
  logic r_wr = 0, r_rd = 0, s_wr = 0, s_rd = 0;
  logic [31:0] r_wd = 0, s_wd = 0, r_rdat, s_rdat;
  logic l_we = 0;
  logic [8:0] l_addr = 0;
  logic [7:0] l_dat = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(TCLK/2) clk = ~clk;

  efuse_rd_ctrl #(.WORD_BYTES(4), .RD_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(r_addr), .reg_wr(r_wr), .reg_rd(r_rd),
    .reg_wdata(r_wd), .reg_rdata(r_rdat), .ld_we(l_we), .ld_addr(l_addr), .ld_data(l_dat));

  efuse_rd_ctrl #(.WORD_BYTES(1), .RD_LAT(LAT)) dut1 (
    .clk(clk), .rst_n(rst_n), .reg_addr(s_addr), .reg_wr(s_wr), .reg_rd(s_rd),
    .reg_wdata(s_wd), .reg_rdata(s_rdat), .ld_we(1'b0), .ld_addr(9'd0), .ld_data(8'd0));

  function automatic logic [31:0] ctl(bit ren, bit pd, bit st, bit aset, logic [10:0] idx);
    return {4'b0, pd, 1'b0, st, ren, 8'b0, 4'b0, aset, idx};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit s, logic [4:0] a, logic [31:0] d);
    if (s) begin s_addr = a; s_wd = d; s_wr = 1; end
    else   begin r_addr = a; r_wd = d; r_wr = 1; end
    @(posedge clk); @(negedge clk);
    r_wr = 0; s_wr = 0;
  endtask

  task automatic rd(bit s, logic [4:0] a, output logic [31:0] d);
    if (s) begin s_addr = a; s_rd = 1; end else begin r_addr = a; r_rd = 1; end
    #1;
    d = s ? s_rdat : r_rdat;
    r_rd = 0; s_rd = 0;
  endtask

  task automatic start_wait(bit s, logic [10:0] idx, output logic b0, output int n,
                            output logic [31:0] d);
    logic [31:0] v;
    wr(s, CTRL, ctl(1, 0, 1, 0, idx));
    rd(s, CTRL, v);
    b0 = v[26];
    n = 0;
    while (v[26] && n < 1000) begin @(negedge clk); n++; rd(s, CTRL, v); end
    wr(s, CTRL, ctl(1, 0, 0, 0, idx));
    rd(s, DATA, d);
  endtask

  task automatic latch(bit s, logic [10:0] idx);
    wr(s, CTRL, ctl(1, 0, 0, 0, idx));
    wr(s, CTRL, ctl(1, 0, 0, 1, idx));
    wr(s, CTRL, ctl(1, 0, 0, 0, idx));
  endtask

  task automatic fuse_read(bit s, logic [10:0] idx, output logic [31:0] d,
                           output logic b0, output int n);
    latch(s, idx);
    start_wait(s, idx, b0, n, d);
  endtask

  initial begin
    #(TCLK * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, d;
    logic b0;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(0, CTRL, v); chk("R1 ctrl", v, 32'h0800_0000);
    rd(0, DATA, v); chk("R1 data", v, 32'h0);
    rd(0, KEYC, v); chk("R1 key", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] idx;
      logic en;
      logic [31:0] ex;
      {idx, en, ex} = VEC[i];
      wr(0, KEYC, {21'b0, en, 10'b0});
      fuse_read(0, idx, d, b0, n);
      if (int'(idx) * 4 >= 512) chk("R8 beyond array", d, ex);
      else if (en)              chk("R7 key xor", d, ex);
      else                      chk("R5 R11 word pack", d, ex);
    end
    wr(0, KEYC, 32'h0);

    fuse_read(0, 11'd2, d, b0, n);
    chk("R3 busy on first read", {31'b0, b0}, 32'h1);
    chk("R3 busy length", n, LAT);

    latch(0, 11'd1);
    wr(0, CTRL, ctl(1, 0, 0, 0, 11'd10));
    start_wait(0, 11'd10, b0, n, d);
    chk("R2 index needs set edge", d, 32'h6F6C6966);

    wr(0, CTRL, ctl(0, 0, 1, 0, 11'd1));
    rd(0, CTRL, v); chk("R4 start without enable", {31'b0, v[26]}, 32'h0);
    wr(0, CTRL, ctl(1, 0, 0, 0, 11'd1));
    wr(0, CTRL, ctl(1, 1, 1, 0, 11'd1));
    rd(0, CTRL, v); chk("R4 start while powered down", {31'b0, v[26]}, 32'h0);
    wr(0, CTRL, ctl(1, 0, 0, 0, 11'd1));

    wr(0, CTRL, ctl(1, 0, 1, 0, 11'd1));
    wr(0, CTRL, ctl(1, 0, 0, 0, 11'd1));
    start_wait(0, 11'd1, b0, n, d);
    chk("R4 restart while busy ignored", n, LAT - 2);
    chk("R4 data after ignored restart", d, 32'h6F6C6966);

    wr(0, CTRL, 32'h08C3_7000);
    rd(0, CTRL, v); chk("R9 write fields", v, 32'h08C3_3000);
    rd(0, DATA, d);
    wr(0, DATA, 32'hFFFF_FFFF);
    rd(0, DATA, v); chk("R9 data read-only", v, d);

    for (int b = 0; b < 4; b++) begin
      l_addr = 9'(40 + b); l_dat = 8'(8'h11 * (b + 1)); l_we = 1;
      @(posedge clk); @(negedge clk);
      l_we = 0;
    end
    fuse_read(0, 11'd10, d, b0, n);
    chk("R10 test load", d, 32'h4433_2211);

    fuse_read(1, 11'd5, d, b0, n);   chk("R6 byte mode index 5", d, 32'h69);
    fuse_read(1, 11'd511, d, b0, n); chk("R6 byte mode last", d, 32'h57);
    fuse_read(1, 11'd512, d, b0, n); chk("R8 byte mode beyond", d, 32'h0);
    chk("R3 byte mode busy length", n, LAT);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule